// File: doc/BRIEF.md
# Raised-Cosine Soft Mute with Lock-Driven Hard Mute

This block sits in a stereo PCM sample path running at the audio sample rate. Each sample that arrives with a strobe is multiplied, on both channels, by a gain that the block manages itself. When a mute is requested, the gain falls from unity to silence along a raised-cosine curve. When the request is withdrawn, the gain climbs back along the same curve. The curve is held as a table of gain levels. The block moves one level after a fixed number of samples, so a full fade is spread over 1024 sample periods by default.

The mute request comes from one of two places, picked by a control-mode input. In pin mode it is a dedicated mute pin. In register mode it is a bit written over a serial control link, and the pin is not looked at. In register mode the block leaves reset already silent and stays that way until the register bit is cleared.

A separate hard mute zeroes the output at once, with no fade, while the upstream decoder reports that it is out of lock. An enable input turns this hard mute off. A status flag shows when the output is silent.

Top module: `pcm_soft_mute`

## Requirements
- R1: At full gain, with no mute request and no hard mute, each output sample equals its input sample exactly on both channels.
- R2: The mute request is `mute_pin` when `reg_mode`=0 and `mt_bit` when `reg_mode`=1. In register mode `mute_pin` has no effect on the output.
- R3: When `reg_mode`=1 during reset, the block leaves reset at zero gain. Outputs are zero and `muted`=1 until `mt_bit` is cleared, and then the gain ramps up.
- R4: Under a steady mute request the gain level index drops by one every 32 accepted samples, from 32 down to 0. Level k has gain round((1-cos(pi*k/32))/2 * 65536), with 65536 as unity. After 1024 samples starting from full gain, the gain is zero.
- R5: Under a steady unmute request the gain follows the same levels upward, one level every 32 samples, until it reaches unity.
- R6: If the request changes in the middle of a ramp, the ramp reverses from the current level. The 32-sample count restarts at the sample where the change is first seen.
- R7: While `auto_en`=1 and `lock`=0, every output sample is zero whatever the mute request. When lock returns, the gain in force is the ramp level, with no fade-in.
- R8: With `auto_en`=0 the lock input has no effect on the output or on `muted`.
- R9: `muted` is 1 exactly when the ramp gain is zero or the hard mute is active.
- R10: `out_valid` pulses one clock after each `in_valid` and is low otherwise. The gain level changes only on accepted samples.
- R11: Outputs are floor((x*g + 32768) / 65536) for a signed sample x and gain g. For example, at half gain 3 becomes 2, -3 becomes -1, and -1 becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| mute_pin | input | 1 | Mute request in pin mode |
| mt_bit | input | 1 | Mute request in register mode |
| reg_mode | input | 1 | 0 = pin mode, 1 = register mode |
| auto_en | input | 1 | Enables the lock-driven hard mute |
| lock | input | 1 | Upstream decoder lock flag |
| out_valid | output | 1 | Output sample strobe |
| out_l | output | 24 | Left output sample, signed |
| out_r | output | 24 | Right output sample, signed |
| muted | output | 1 | Output is silent |

## Verification
The hardest state to reach is a reversal at an exactly known level. It needs a long run of strobed samples under one request and then a change of request partway through a level. The bench keeps its own model of the level index and of the 32-sample counter. It drives 512 samples down to the half-gain level and flips the request there, which checks both the reversal point and exact rounding at a gain of exactly one half. The full 1024-sample fades down and up are then compared sample by sample against gains computed from the cosine.

// File: rtl/pcm_soft_mute.sv
module pcm_soft_mute #(
  parameter int DATA_W    = 24,
  parameter int STEPS     = 32,
  parameter int HOLD      = 32,
  parameter int GAIN_FRAC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_l,
  input  logic [DATA_W-1:0] in_r,
  input  logic              mute_pin,
  input  logic              mt_bit,
  input  logic              reg_mode,
  input  logic              auto_en,
  input  logic              lock,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_l,
  output logic [DATA_W-1:0] out_r,
  output logic              muted
);

  localparam int POS_W  = $clog2(STEPS + 1);
  localparam int SUB_W  = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam int GAIN_W = GAIN_FRAC + 1;
  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam longint Q  = 28;
  localparam longint PI_Q = 64'sd843314857;

  function automatic logic [GAIN_W-1:0] rc_gain(input int idx);
    longint one, t, t2, term, c, g;
    one  = 64'sd1 <<< Q;
    t    = (PI_Q * idx) / STEPS;
    t2   = (t * t) >>> Q;
    term = one;
    c    = one;
    for (int k = 1; k <= 12; k++) begin
      term = -((term * t2) >>> Q) / ((2 * k - 1) * (2 * k));
      c    = c + term;
    end
    g = ((one - c) + (64'sd1 <<< (Q - GAIN_FRAC))) >>> (Q + 1 - GAIN_FRAC);
    if (g < 0) g = 0;
    if (g > (64'sd1 <<< GAIN_FRAC)) g = 64'sd1 <<< GAIN_FRAC;
    return g[GAIN_W-1:0];
  endfunction

  logic [GAIN_W-1:0] lut [STEPS+1];
  for (genvar i = 0; i <= STEPS; i++) begin : g_lut
    localparam logic [GAIN_W-1:0] LEVEL = rc_gain(i);
    assign lut[i] = LEVEL;
  end

  logic [POS_W-1:0] pos_q;
  logic [SUB_W-1:0] sub_q;
  logic             last_req;

  wire req  = reg_mode ? mt_bit : mute_pin;
  wire hard = auto_en & ~lock;
  wire [POS_W-1:0] target  = req ? '0 : POS_W'(STEPS);
  wire [SUB_W-1:0] sub_eff = (req != last_req) ? '0 : sub_q;
  wire [GAIN_W-1:0] gain   = lut[pos_q];

  function automatic logic [DATA_W-1:0] scale(input logic [DATA_W-1:0] x,
                                               input logic [GAIN_W-1:0] g);
    logic signed [PROD_W-1:0] p;
    p = $signed(x) * $signed({1'b0, g});
    p = p + (PROD_W'(1) <<< (GAIN_FRAC - 1));
    p = p >>> GAIN_FRAC;
    return p[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= reg_mode ? '0 : POS_W'(STEPS);
      sub_q     <= '0;
      last_req  <= reg_mode;
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        last_req <= req;
        out_l    <= hard ? '0 : scale(in_l, gain);
        out_r    <= hard ? '0 : scale(in_r, gain);
        if (pos_q == target) begin
          sub_q <= '0;
        end else if (sub_eff == SUB_W'(HOLD - 1)) begin
          sub_q <= '0;
          pos_q <= req ? pos_q - 1'b1 : pos_q + 1'b1;
        end else begin
          sub_q <= sub_eff + 1'b1;
        end
      end
    end
  end

  assign muted = (pos_q == '0) | hard;

endmodule

// File: rtl/psm_checker.sv
module psm_checker #(
  parameter int DATA_W = 24,
  parameter int STEPS  = 32,
  parameter int POS_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_l,
  input logic              auto_en,
  input logic              lock,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_l,
  input logic [DATA_W-1:0] out_r,
  input logic              muted,
  input logic [POS_W-1:0]  pos_q
);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r10_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r10_level_moves_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pos_q));

  a_r4_single_level_step: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (pos_q == $past(pos_q) || pos_q == $past(pos_q) + 1'b1 ||
                  pos_q + 1'b1 == $past(pos_q)));

  a_r7_hard_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && auto_en && !lock) |=> (out_l == '0 && out_r == '0));

  a_r1_full_gain_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pos_q == POS_W'(STEPS) && !(auto_en && !lock)) |=> out_l == $past(in_l));

  a_r9_zero_level_muted: assert property (@(posedge clk) disable iff (rst)
    (pos_q == '0) |-> muted);

endmodule

bind pcm_soft_mute psm_checker #(.DATA_W(DATA_W), .STEPS(STEPS), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_l(in_l), .auto_en(auto_en),
  .lock(lock), .out_valid(out_valid), .out_l(out_l), .out_r(out_r),
  .muted(muted), .pos_q(pos_q));

// File: tb/pcm_soft_mute_bench.sv
module pcm_soft_mute_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [23:0] in_l = 0, in_r = 0;
  logic mute_pin = 0, mt_bit = 0, reg_mode = 0, auto_en = 1, lock = 1;
  logic out_valid, muted;
  logic [23:0] out_l, out_r;

  int n_chk = 0, n_bad = 0;
  int m_pos, m_sub;
  bit m_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_soft_mute u_pcm_soft_mute (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
    .mute_pin(mute_pin), .mt_bit(mt_bit), .reg_mode(reg_mode),
    .auto_en(auto_en), .lock(lock), .out_valid(out_valid),
    .out_l(out_l), .out_r(out_r), .muted(muted));

  task automatic check(string tag, longint act, longint exp, longint tol);
    longint d;
    d = act - exp;
    if (d < 0) d = -d;
    n_chk++;
    if (d > tol) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint gexp(int k);
    real g;
    g = (1.0 - $cos(3.141592653589793 * k / 32.0)) / 2.0 * 65536.0;
    return longint'($rtoi(g + 0.5));
  endfunction

  function automatic longint sx(logic [23:0] v);
    return longint'($signed(v));
  endfunction

  function automatic bit cur_req();
    return reg_mode ? mt_bit : mute_pin;
  endfunction

  function automatic bit cur_hard();
    return auto_en && !lock;
  endfunction

  task automatic model_step();
    bit r;
    int se;
    r = cur_req();
    se = (r != m_last) ? 0 : m_sub;
    m_last = r;
    if (m_pos == (r ? 0 : 32)) m_sub = 0;
    else if (se == 31) begin m_sub = 0; m_pos = r ? m_pos - 1 : m_pos + 1; end
    else m_sub = se + 1;
  endtask

  task automatic do_reset(bit mode);
    rst = 1; reg_mode = mode; in_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    m_pos = mode ? 0 : 32; m_sub = 0; m_last = mode;
    @(negedge clk);
    check("R10 reset out_valid", out_valid, 0, 0);
    check("R3 reset out_l", sx(out_l), 0, 0);
  endtask

  task automatic send_one(string tag, longint l, longint r, bit exact);
    longint g, el, er, tl, tr;
    g  = cur_hard() ? 0 : gexp(m_pos);
    el = (l * g + 32768) >>> 16;
    er = (r * g + 32768) >>> 16;
    tl = exact ? 0 : ((l < 0 ? -l : l) >>> 16) + 2;
    tr = exact ? 0 : ((r < 0 ? -r : r) >>> 16) + 2;
    in_l = l[23:0]; in_r = r[23:0]; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    model_step();
    check({tag, " valid"}, out_valid, 1, 0);
    check({tag, " left"}, sx(out_l), el, tl);
    check({tag, " right"}, sx(out_r), er, tr);
    check({tag, " muted"}, muted, (m_pos == 0 || cur_hard()) ? 1 : 0, 0);
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) send_one(tag, 4194304, -4194304, 0);
  endtask

  task automatic t_pass();
    mute_pin = 0; lock = 1; auto_en = 1;
    do_reset(0);
    check("R9 idle not muted", muted, 0, 0);
    send_one("R1 max", 8388607, -8388608, 1);
    send_one("R1 mix", 1193046, -1, 1);
    send_one("R1 zero", 0, 5, 1);
    repeat (3) @(negedge clk);
    check("R10 idle valid low", out_valid, 0, 0);
    send_one("R10 level held", 100, -100, 1);
  endtask

  task automatic t_ramp();
    mute_pin = 1;
    run("R4 fade down", 1023);
    check("R4 not silent at 1023", muted, 0, 0);
    run("R4 fade down", 1);
    check("R4 silent at 1024", muted, 1, 0);
    send_one("R4 zero gain", 8388607, -8388608, 1);
    mute_pin = 0;
    run("R5 fade up", 1024);
    send_one("R5 back to unity", 8388607, -8388608, 1);
  endtask

  task automatic t_reverse();
    mute_pin = 1;
    run("R6 down part", 511);
    send_one("R6 down part", 4194304, -4194304, 0);
    check("R6 model at half level", m_pos, 16, 0);
    mute_pin = 0;
    send_one("R11 half 3/-3", 3, -3, 1);
    send_one("R11 half 1/-1", 1, -1, 1);
    run("R6 reversed", 200);
    mute_pin = 1;
    run("R6 reversed again", 70);
    mute_pin = 0;
    run("R6 recover", 1024);
    send_one("R6 unity", 77, -77, 1);
  endtask

  task automatic t_hard();
    auto_en = 1; lock = 0;
    send_one("R7 hard zero", 1048576, -1048576, 1);
    check("R9 hard muted", muted, 1, 0);
    mute_pin = 1;
    send_one("R7 hard with request", 1048576, 3, 1);
    mute_pin = 0;
    lock = 1;
    send_one("R7 no fade on relock", 1048576, -1048576, 1);
    auto_en = 0; lock = 0;
    check("R8 not muted", muted, 0, 0);
    send_one("R8 lock ignored", 2097152, -7, 1);
    auto_en = 1; lock = 1;
  endtask

  task automatic t_regmode();
    mt_bit = 1; mute_pin = 0;
    do_reset(1);
    check("R3 muted after reset", muted, 1, 0);
    send_one("R3 silent", 8388607, -8388608, 1);
    mute_pin = 1;
    send_one("R2 pin ignored while MT", 8388607, 5, 1);
    mt_bit = 0;
    run("R3 ramp up after clear", 1024);
    send_one("R2 pin ignored at unity", 8388607, -8388608, 1);
    mute_pin = 0;
    mt_bit = 1;
    run("R2 MT fades", 40);
    check("R2 model moved", m_pos, 31, 0);
  endtask

  initial begin
    t_pass();
    t_ramp();
    t_reverse();
    t_hard();
    t_regmode();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule